// File: doc/BRIEF.md
# I2C Target Receive Event Tagger

This block sits behind the byte engine of an I2C target. The engine reports three kinds of bus event: a start (or repeated start) condition, a complete received byte, and a stop condition. The tagger compares the first byte after each start with a programmable 7-bit own address. When a write is addressed to this target, it turns the byte stream into entries of a receive FIFO. Each entry carries a 2-bit tag that marks where the byte sits in its frame. Software, or a sequencer, pops entries one at a time and reads the tag beside the byte, so frame boundaries need no separate bookkeeping.

The tag of a byte cannot be known until the event that follows it. To handle this, the tagger holds each payload byte one stage back and commits it only when the next byte, a stop, or a repeated start arrives. A write that is followed by a repeated start with a matching read address is closed with an end tag, and a read-request event is raised. Sticky status bits record three conditions: entries present, FIFO full, and read request. Each bit is cleared by writing 1 to it, and each has its own enable into a single interrupt line.

Top module: `i2c_tgt_rx_tagger`

## Requirements
- R1: Register select 0 holds the own address in write-data bits 6:0 and an enable in bit 7. The address byte after a start is compared using its bits 7:1. When the enable is clear, or the address differs, nothing from that frame is queued.
- R2: A matching address byte with bit 0 low (a write) is queued at once with tag 1 (start), and the address byte itself is the data.
- R3: Payload bytes of a matched write are queued in arrival order. Every byte has tag 2 (data), except the byte directly before a stop, which has tag 3 (end).
- R4: A repeated start closes an open write frame by queuing its held byte with tag 3. If a matching read address (bit 0 high) then follows a matched write within the same start-to-stop span, status bit 2 (read request) is set.
- R5: A pop pulse on rx_pop updates rx_word on the next clock edge. rx_word carries the tag in bits 31:30 and the byte in bits 7:0, with all other bits zero. A pop while the FIFO is empty returns tag 0 with a zero byte.
- R6: The FIFO holds FIFO_DEPTH entries. An entry that arrives while the FIFO is full is dropped. Status bit 1 is set while the FIFO is full.
- R7: Status bit 0 (receive event) is set while the FIFO holds at least one entry.
- R8: Register select 3 clears status bits where the write data has a 1. A set condition in the same cycle wins over the clear. Register select 2 holds the per-bit enables. irq is the registered OR of the enabled status bits.
- R9: At register select 1, a 1 in write-data bit 31 empties the receive FIFO. A 1 in bit 30 gives a single-cycle pulse on tx_flush.
- R10: A matching read address that does not follow a matched write since the last stop queues nothing and sets no read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_start | input | 1 | Start or repeated start seen on the bus |
| ev_byte_vld | input | 1 | A received byte is on ev_byte |
| ev_byte | input | 8 | Received byte |
| ev_stop | input | 1 | Stop seen on the bus |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 address, 1 FIFO control, 2 interrupt enable, 3 status clear |
| reg_wdata | input | 32 | Register write data |
| rx_pop | input | 1 | Pop one receive entry |
| rx_word | output | 32 | Last popped entry: tag in 31:30, byte in 7:0 |
| irq_stat | output | 3 | Sticky status: 0 receive event, 1 FIFO full, 2 read request |
| irq | output | 1 | Interrupt |
| tx_flush | output | 1 | Transmit FIFO flush pulse |

## Verification
The bench builds the block with FIFO_DEPTH set to 4. This lets a single six-entry write frame fill the FIFO, which exercises the drop of the late payload bytes and the full status bit. The same small depth is deep enough for the frames that check the start, data and end tags. All other parameters keep their defaults. Scenarios cover a disabled address, a wrong address, a plain write, a combined write-then-read and a bare read, so that both the repeated-start closing path and the read-request gating are reached.

// File: rtl/i2c_tgt_rx_pkg.sv
package i2c_tgt_rx_pkg;
  typedef enum logic [1:0] {
    TAG_EMPTY = 2'd0,
    TAG_START = 2'd1,
    TAG_DATA  = 2'd2,
    TAG_END   = 2'd3
  } rx_tag_e;

  typedef struct packed {
    rx_tag_e    tag;
    logic [7:0] data;
  } rx_entry_t;

  localparam int unsigned STAT_W     = 3;
  localparam int unsigned STAT_RXEV  = 0;
  localparam int unsigned STAT_FULL  = 1;
  localparam int unsigned STAT_RDREQ = 2;

  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_FCTL = 2'd1;
  localparam logic [1:0] SEL_IEN  = 2'd2;
  localparam logic [1:0] SEL_STAT = 2'd3;

  localparam int unsigned FCTL_RX_FLUSH_BIT = 31;
  localparam int unsigned FCTL_TX_FLUSH_BIT = 30;
endpackage

// File: rtl/tgt_frame_tagger.sv
module tgt_frame_tagger
  import i2c_tgt_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ev_start,
  input  logic       ev_byte_vld,
  input  logic [7:0] ev_byte,
  input  logic       ev_stop,
  input  logic [6:0] own_addr,
  input  logic       addr_en,
  output logic       push_vld,
  output rx_entry_t  push_entry,
  output logic       rd_req
);
  logic       expect_addr;
  logic       in_frame;
  logic       wr_seen;
  logic       pend_vld;
  logic [7:0] pend_data;
  logic       hit;

  assign hit = addr_en && (ev_byte[7:1] == own_addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      expect_addr <= 1'b0;
      in_frame    <= 1'b0;
      wr_seen     <= 1'b0;
      pend_vld    <= 1'b0;
      pend_data   <= '0;
      push_vld    <= 1'b0;
      push_entry  <= '0;
      rd_req      <= 1'b0;
    end else begin
      push_vld <= 1'b0;
      rd_req   <= 1'b0;
      if (ev_start) begin
        if (pend_vld) begin
          push_vld   <= 1'b1;
          push_entry <= '{tag: TAG_END, data: pend_data};
        end
        pend_vld    <= 1'b0;
        expect_addr <= 1'b1;
        in_frame    <= 1'b0;
      end else if (ev_stop) begin
        if (pend_vld) begin
          push_vld   <= 1'b1;
          push_entry <= '{tag: TAG_END, data: pend_data};
        end
        pend_vld    <= 1'b0;
        expect_addr <= 1'b0;
        in_frame    <= 1'b0;
        wr_seen     <= 1'b0;
      end else if (ev_byte_vld) begin
        if (expect_addr) begin
          expect_addr <= 1'b0;
          if (hit && !ev_byte[0]) begin
            push_vld   <= 1'b1;
            push_entry <= '{tag: TAG_START, data: ev_byte};
            in_frame   <= 1'b1;
            wr_seen    <= 1'b1;
          end else if (hit && ev_byte[0] && wr_seen) begin
            rd_req <= 1'b1;
          end
        end else if (in_frame) begin
          if (pend_vld) begin
            push_vld   <= 1'b1;
            push_entry <= '{tag: TAG_DATA, data: pend_data};
          end
          pend_data <= ev_byte;
          pend_vld  <= 1'b1;
        end
      end
    end
  end

  // R2: a start entry always comes from a write address byte one cycle earlier
  a_r2_start_from_write_addr: assert property (@(posedge clk) disable iff (rst)
    (push_vld && push_entry.tag == TAG_START) |-> ($past(ev_byte_vld) && !$past(ev_byte[0])));

  // R3: the entry produced by a stop can only be an end entry
  a_r3_stop_gives_end: assert property (@(posedge clk) disable iff (rst)
    ev_stop |=> (!push_vld || push_entry.tag == TAG_END));

  // R4: a read request follows a read address byte
  a_r4_rdreq_after_read_addr: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> ($past(ev_byte_vld) && $past(ev_byte[0])));

  // R4: a read request lasts a single cycle
  a_r4_rdreq_pulse: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> !rd_req);
endmodule

// File: rtl/tgt_rx_fifo.sv
module tgt_rx_fifo
  import i2c_tgt_rx_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      flush,
  input  logic      push,
  input  rx_entry_t din,
  input  logic      pop,
  output rx_entry_t dout,
  output logic      empty,
  output logic      full
);
  localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = AW + 1;
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  rx_entry_t        mem [DEPTH];
  logic [CNT_W-1:0] wr_ptr;
  logic [CNT_W-1:0] rd_ptr;
  logic [CNT_W-1:0] count;
  logic             wr_en;
  logic             rd_en;
  rx_entry_t        rd_raw;
  logic             rd_hit;

  assign count = wr_ptr - rd_ptr;
  assign empty = (count == '0);
  assign full  = (count == DEPTH_C);
  assign wr_en = push && !full && !flush;
  assign rd_en = pop && !empty && !flush;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr[AW-1:0]] <= din;
  end

  always_ff @(posedge clk) begin
    if (pop) rd_raw <= mem[rd_ptr[AW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      rd_hit <= 1'b0;
    end else begin
      if (flush) begin
        wr_ptr <= '0;
        rd_ptr <= '0;
      end else begin
        if (wr_en) wr_ptr <= wr_ptr + 1'b1;
        if (rd_en) rd_ptr <= rd_ptr + 1'b1;
      end
      if (pop) rd_hit <= rd_en;
    end
  end

  assign dout = rd_hit ? rd_raw : '0;

  // R6: occupancy never exceeds the depth
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
    count <= DEPTH_C);

  // R6: a push into a full FIFO without pop or flush leaves it full
  a_r6_full_holds: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop && !flush) |=> full);

  // R9: flush leaves nothing to read
  a_r9_flush_empties: assert property (@(posedge clk) disable iff (rst)
    (flush && !push) |=> empty);
endmodule

// File: rtl/tgt_irq_ctrl.sv
module tgt_irq_ctrl
  import i2c_tgt_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [STAT_W-1:0] set_vec,
  input  logic              clr_we,
  input  logic [STAT_W-1:0] clr_vec,
  input  logic              ien_we,
  input  logic [STAT_W-1:0] ien_wdata,
  output logic [STAT_W-1:0] stat,
  output logic              irq
);
  logic [STAT_W-1:0] ien;
  logic [STAT_W-1:0] clr_mask;

  assign clr_mask = clr_we ? clr_vec : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat <= '0;
      ien  <= '0;
      irq  <= 1'b0;
    end else begin
      stat <= (stat & ~clr_mask) | set_vec;
      if (ien_we) ien <= ien_wdata;
      irq <= |(stat & ien);
    end
  end

  for (genvar i = 0; i < STAT_W; i++) begin : g_sticky
    // R8: a status bit stays set until written with 1
    a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
      (stat[i] && !clr_mask[i]) |=> stat[i]);
  end

  // R8: no interrupt can follow a cycle without any status bit
  a_r8_irq_needs_status: assert property (@(posedge clk) disable iff (rst)
    (stat == '0) |=> !irq);
endmodule

// File: rtl/i2c_tgt_rx_tagger.sv
module i2c_tgt_rx_tagger
  import i2c_tgt_rx_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 16,
  parameter int unsigned WORD_W     = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ev_start,
  input  logic        ev_byte_vld,
  input  logic [7:0]  ev_byte,
  input  logic        ev_stop,
  input  logic        reg_we,
  input  logic [1:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  input  logic        rx_pop,
  output logic [31:0] rx_word,
  output logic [2:0]  irq_stat,
  output logic        irq,
  output logic        tx_flush
);
  localparam int unsigned PAD_W = WORD_W - 2 - 8;

  logic [6:0]        own_addr;
  logic              addr_en;
  logic              push_vld;
  rx_entry_t         push_entry;
  logic              rd_req;
  logic              rx_flush;
  rx_entry_t         head;
  logic              f_empty;
  logic              f_full;
  logic [STAT_W-1:0] set_vec;

  always_ff @(posedge clk) begin
    if (rst) begin
      own_addr <= '0;
      addr_en  <= 1'b0;
      tx_flush <= 1'b0;
    end else begin
      if (reg_we && reg_sel == SEL_ADDR) begin
        own_addr <= reg_wdata[6:0];
        addr_en  <= reg_wdata[7];
      end
      tx_flush <= reg_we && (reg_sel == SEL_FCTL) && reg_wdata[FCTL_TX_FLUSH_BIT];
    end
  end

  assign rx_flush = reg_we && (reg_sel == SEL_FCTL) && reg_wdata[FCTL_RX_FLUSH_BIT];

  tgt_frame_tagger u_tagger (
    .clk        (clk),
    .rst        (rst),
    .ev_start   (ev_start),
    .ev_byte_vld(ev_byte_vld),
    .ev_byte    (ev_byte),
    .ev_stop    (ev_stop),
    .own_addr   (own_addr),
    .addr_en    (addr_en),
    .push_vld   (push_vld),
    .push_entry (push_entry),
    .rd_req     (rd_req)
  );

  tgt_rx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk  (clk),
    .rst  (rst),
    .flush(rx_flush),
    .push (push_vld),
    .din  (push_entry),
    .pop  (rx_pop),
    .dout (head),
    .empty(f_empty),
    .full (f_full)
  );

  always_comb begin
    set_vec             = '0;
    set_vec[STAT_RXEV]  = !f_empty;
    set_vec[STAT_FULL]  = f_full;
    set_vec[STAT_RDREQ] = rd_req;
  end

  tgt_irq_ctrl u_irq (
    .clk      (clk),
    .rst      (rst),
    .set_vec  (set_vec),
    .clr_we   (reg_we && reg_sel == SEL_STAT),
    .clr_vec  (reg_wdata[STAT_W-1:0]),
    .ien_we   (reg_we && reg_sel == SEL_IEN),
    .ien_wdata(reg_wdata[STAT_W-1:0]),
    .stat     (irq_stat),
    .irq      (irq)
  );

  assign rx_word = {head.tag, {PAD_W{1'b0}}, head.data};

  // R3: bus events from the byte engine arrive one at a time
  a_r3_events_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ev_start, ev_byte_vld, ev_stop}));

  // R9: the transmit flush is a single-cycle pulse for a single write
  a_r9_txflush_pulse: assert property (@(posedge clk) disable iff (rst)
    (tx_flush && !$past(reg_we)) |-> 1'b0);
endmodule

// File: tb/i2c_tgt_rx_tagger_bench.sv
module i2c_tgt_rx_tagger_bench;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ev_start = 1'b0, ev_byte_vld = 1'b0, ev_stop = 1'b0;
  logic [7:0]  ev_byte = '0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic        rx_pop = 1'b0;
  logic [31:0] rx_word;
  logic [2:0]  irq_stat;
  logic        irq, tx_flush;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  i2c_tgt_rx_tagger #(.FIFO_DEPTH(DEPTH)) u_i2c_tgt_rx_tagger (
    .clk(clk), .rst(rst), .ev_start(ev_start), .ev_byte_vld(ev_byte_vld),
    .ev_byte(ev_byte), .ev_stop(ev_stop), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .rx_pop(rx_pop), .rx_word(rx_word),
    .irq_stat(irq_stat), .irq(irq), .tx_flush(tx_flush)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic bus_start();
    ev_start = 1'b1; @(negedge clk); ev_start = 1'b0; @(negedge clk);
  endtask

  task automatic bus_stop();
    ev_stop = 1'b1; @(negedge clk); ev_stop = 1'b0; @(negedge clk);
  endtask

  task automatic bus_byte(logic [7:0] b);
    ev_byte = b; ev_byte_vld = 1'b1; @(negedge clk); ev_byte_vld = 1'b0; @(negedge clk);
  endtask

  task automatic wr_reg(logic [1:0] sel, logic [31:0] d);
    reg_sel = sel; reg_wdata = d; reg_we = 1'b1; @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic pop_expect(string req, logic [1:0] tag, logic [7:0] b);
    rx_pop = 1'b1; @(negedge clk); rx_pop = 1'b0;
    check(req, rx_word, {tag, 22'd0, b});
  endtask

  task automatic t_reset();
    check("R5 reset word", rx_word, 32'h0);
    check("R8 reset status", {29'd0, irq_stat}, 32'h0);
    check("R8 reset irq", {31'd0, irq}, 32'h0);
  endtask

  task automatic t_disabled();
    wr_reg(2'd0, 32'h0000_002A);
    bus_start(); bus_byte(8'h54); bus_byte(8'h11); bus_stop(); idle(3);
    check("R1 disabled no status", {29'd0, irq_stat}, 32'h0);
    pop_expect("R1 disabled queues nothing", 2'd0, 8'h00);
  endtask

  task automatic t_write();
    wr_reg(2'd0, 32'h0000_00AA);
    wr_reg(2'd2, 32'h0000_0001);
    bus_start(); bus_byte(8'h54); bus_byte(8'h11); bus_byte(8'h22); bus_byte(8'h33);
    bus_stop(); idle(3);
    check("R7 receive event set", {31'd0, irq_stat[0]}, 32'h1);
    check("R8 irq from enabled bit", {31'd0, irq}, 32'h1);
    pop_expect("R2 start entry", 2'd1, 8'h54);
    pop_expect("R3 first data", 2'd2, 8'h11);
    pop_expect("R3 second data", 2'd2, 8'h22);
    pop_expect("R3 end entry", 2'd3, 8'h33);
    pop_expect("R5 empty pop", 2'd0, 8'h00);
    idle(1);
    check("R8 sticky after empty", {31'd0, irq_stat[0]}, 32'h1);
    wr_reg(2'd3, 32'h7); idle(2);
    check("R8 cleared status", {29'd0, irq_stat}, 32'h0);
    check("R8 irq dropped", {31'd0, irq}, 32'h0);
  endtask

  task automatic t_mismatch();
    bus_start(); bus_byte(8'h56); bus_byte(8'h77); bus_stop(); idle(3);
    pop_expect("R1 wrong address queues nothing", 2'd0, 8'h00);
  endtask

  task automatic t_combined();
    bus_start(); bus_byte(8'h54); bus_byte(8'hA5);
    bus_start(); bus_byte(8'h55); idle(2);
    check("R4 read request", {31'd0, irq_stat[2]}, 32'h1);
    bus_stop(); idle(2);
    pop_expect("R4 start entry", 2'd1, 8'h54);
    pop_expect("R4 end on repeated start", 2'd3, 8'hA5);
    pop_expect("R4 nothing more", 2'd0, 8'h00);
    wr_reg(2'd3, 32'h7); idle(2);
  endtask

  task automatic t_plain_read();
    bus_start(); bus_byte(8'h55); bus_stop(); idle(3);
    check("R10 no read request", {29'd0, irq_stat}, 32'h0);
    pop_expect("R10 nothing queued", 2'd0, 8'h00);
  endtask

  task automatic t_overflow();
    bus_start(); bus_byte(8'h54);
    for (int i = 0; i < 5; i++) bus_byte(8'h60 + 8'(i));
    bus_stop(); idle(3);
    check("R6 full status", {30'd0, irq_stat[1:0]}, 32'h3);
    pop_expect("R6 kept start", 2'd1, 8'h54);
    pop_expect("R6 kept data0", 2'd2, 8'h60);
    pop_expect("R6 kept data1", 2'd2, 8'h61);
    pop_expect("R6 kept data2", 2'd2, 8'h62);
    pop_expect("R6 late bytes dropped", 2'd0, 8'h00);
    wr_reg(2'd3, 32'h7); idle(2);
  endtask

  task automatic t_flush();
    bus_start(); bus_byte(8'h54); bus_byte(8'h99); bus_stop(); idle(3);
    wr_reg(2'd1, 32'h8000_0000); idle(1);
    pop_expect("R9 receive flush", 2'd0, 8'h00);
    reg_sel = 2'd1; reg_wdata = 32'h4000_0000; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
    check("R9 tx flush pulse", {31'd0, tx_flush}, 32'h1);
    @(negedge clk);
    check("R9 tx flush one cycle", {31'd0, tx_flush}, 32'h0);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    idle(4);
    rst = 1'b0;
    idle(1);
    t_reset();
    t_disabled();
    t_write();
    t_mismatch();
    t_combined();
    t_plain_read();
    t_overflow();
    t_flush();
    finish_run();
  end

  initial begin
    #400000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule